// File: doc/BRIEF.md
# Parallel Row-Slice Thinning Datapath

This block performs one erosion step of a two-pass thinning method for bilevel images. Each step works on a strip of eight adjacent pixels of one image row. The host supplies a 30-bit word that holds three stacked rows of ten pixels: the row above, the current row and the row below. The word is split into eight overlapping 3x3 windows. Each window feeds its own erosion cell, and all eight cells work in the same cycle. Each cell decides whether its centre pixel may be removed. A pixel is removed only when four tests all hold: its neighbour count, its ring connectivity, the rule of the selected pass, and the pixel being set.

Both the input and the output pass through registers. The per-cell removal flags are OR-reduced into a sticky change flag. The host reads this flag after a full sweep of the image to decide whether another iteration is needed, and clears it before the next sweep. The first and last pixel of each ten-pixel row serve only as neighbour context. To cover a whole image row, the host overlaps successive groups by two columns.

Top module: `skel_row_datapath`

## Requirements
- R1: Bit fields of `rows_i`. Bits [29:20] hold the row above, bits [19:10] the current row and bits [9:0] the row below. Within a row, bit c is column c, and east is the higher column. Output bit k of `pix_o` is the new value of current-row column k+1. It is computed from the window of columns k..k+2.
- R2: A background (0) centre pixel stays 0. A set centre pixel becomes 0 when all of the following hold: it has between 2 and 6 set neighbours inclusive, and exactly one 0-to-1 transition occurs in the clockwise ring N, NE, E, SE, S, SW, W, NW, N. Otherwise it stays 1.
- R3: With `pass_sel_i`=0, removal additionally needs (N&E&S)=0 and (E&S&W)=0. With `pass_sel_i`=1, it needs (N&E&W)=0 and (N&S&W)=0. The pass select is captured together with the data.
- R4: When `in_valid_i` is high at clock edge E, `pix_o` and `out_valid_o`=1 appear after edge E+1. In a cycle after an edge that captured no input, `out_valid_o` is 0 and `pix_o` holds its last value.
- R5: `change_o` becomes 1 after the edge at which a valid result removes at least one pixel.
- R6: `change_o` stays 1 until an edge at which `change_clr_i` is high and no removing result is being registered.
- R7: If `change_clr_i` is high at the same edge as a removing result, the set wins and `change_o` stays 1.
- R8: After synchronous reset, `pix_o`, `out_valid_o` and `change_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Captures `rows_i` and `pass_sel_i` |
| rows_i | input | 30 | Three stacked 10-pixel rows |
| pass_sel_i | input | 1 | Pass rule select (0 first, 1 second) |
| change_clr_i | input | 1 | Clears the sticky change flag |
| pix_o | output | 8 | New values of the eight interior pixels |
| out_valid_o | output | 1 | `pix_o` holds a fresh result |
| change_o | output | 1 | Sticky: some pixel was removed |

## Verification
The host's clear of the change flag can land on the same edge as a result that removes pixels. The bench provokes this by raising `change_clr_i` exactly one cycle after loading a word that it knows will erode. It then expects `change_o` to remain 1, and to drop only after a later clear with no result pending. The erosion outcome itself is judged by sweeping all 512 window patterns under both pass rules at shifting column offsets. Each result is compared with an arithmetic model of the thinning rules, while the model also tracks the expected sticky flag.

// File: rtl/skel_pkg.sv
package skel_pkg;

    localparam int unsigned SLICES  = 8;
    localparam int unsigned ROW_W   = SLICES + 2;
    localparam int unsigned WORD_W  = 3 * ROW_W;
    localparam int unsigned RING_N  = 8;
    localparam int unsigned CNT_W   = $clog2(RING_N + 1);
    localparam int unsigned MIN_NBR = 2;
    localparam int unsigned MAX_NBR = 6;

    typedef struct packed {
        logic nw;
        logic n;
        logic ne;
        logic w;
        logic c;
        logic e;
        logic sw;
        logic s;
        logic se;
    } win_t;

    typedef enum logic {
        PASS_FIRST  = 1'b0,
        PASS_SECOND = 1'b1
    } pass_e;

    // Ring in clockwise order starting at north: bit 0 = N ... bit 7 = NW
    function automatic logic [RING_N-1:0] ring_of(win_t w);
        return {w.nw, w.w, w.sw, w.s, w.se, w.e, w.ne, w.n};
    endfunction

    function automatic logic [CNT_W-1:0] ring_pop(logic [RING_N-1:0] r);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < RING_N; i++) acc = acc + CNT_W'(r[i]);
        return acc;
    endfunction

    function automatic logic [CNT_W-1:0] ring_rises(logic [RING_N-1:0] r);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < RING_N; i++)
            acc = acc + CNT_W'(~r[i] & r[(i + 1) % RING_N]);
        return acc;
    endfunction

    function automatic logic pass_ok(win_t w, pass_e p);
        if (p == PASS_FIRST)
            return ~(w.n & w.e & w.s) & ~(w.e & w.s & w.w);
        return ~(w.n & w.e & w.w) & ~(w.n & w.s & w.w);
    endfunction

endpackage

// File: rtl/skel_cell.sv
module skel_cell
    import skel_pkg::*;
(
    input  win_t  win_i,
    input  pass_e pass_i,
    output logic  pix_o,
    output logic  removed_o
);
    logic [RING_N-1:0] ring;
    logic [CNT_W-1:0]  nbr_cnt;
    logic [CNT_W-1:0]  rises;
    logic              cnt_ok;
    logic              conn_ok;
    logic              rule_ok;

    always_comb begin
        ring    = ring_of(win_i);
        nbr_cnt = ring_pop(ring);
        rises   = ring_rises(ring);
        cnt_ok  = (nbr_cnt >= CNT_W'(MIN_NBR)) && (nbr_cnt <= CNT_W'(MAX_NBR));
        conn_ok = (rises == CNT_W'(1));
        rule_ok = pass_ok(win_i, pass_i);
        removed_o = win_i.c & cnt_ok & conn_ok & rule_ok;
        pix_o     = win_i.c & ~removed_o;
    end
endmodule

// File: rtl/skel_change_tree.sv
module skel_change_tree #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] flag_i,
    output logic         any_o
);
    localparam int unsigned LVL  = (N > 1) ? $clog2(N) : 0;
    localparam int unsigned LEAF = 1 << LVL;

    logic [2*LEAF-1:1] node;

    genvar j;
    generate
        for (j = 0; j < LEAF; j++) begin : g_leaf
            if (j < N) begin : g_real
                assign node[LEAF + j] = flag_i[j];
            end else begin : g_pad
                assign node[LEAF + j] = 1'b0;
            end
        end
        for (j = 1; j < LEAF; j++) begin : g_inner
            assign node[j] = node[2*j] | node[2*j + 1];
        end
    endgenerate

    assign any_o = node[1];
endmodule

// File: rtl/skel_row_datapath.sv
module skel_row_datapath
    import skel_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                in_valid_i,
    input  logic [WORD_W-1:0]   rows_i,
    input  logic                pass_sel_i,
    input  logic                change_clr_i,
    output logic [SLICES-1:0]   pix_o,
    output logic                out_valid_o,
    output logic                change_o
);
    logic [WORD_W-1:0] word_q;
    pass_e             pass_q;
    logic              vld_q;

    logic [ROW_W-1:0]  row_up, row_cur, row_dn;
    win_t              win   [SLICES];
    logic [SLICES-1:0] new_pix;
    logic [SLICES-1:0] removed;
    logic              any_removed;

    logic [SLICES-1:0] pix_q;
    logic              ovld_q;
    logic              chg_q;

    // Input stage
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '0;
            pass_q <= PASS_FIRST;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= in_valid_i;
            if (in_valid_i) begin
                word_q <= rows_i;
                pass_q <= pass_e'(pass_sel_i);
            end
        end
    end

    assign row_up  = word_q[3*ROW_W-1:2*ROW_W];
    assign row_cur = word_q[2*ROW_W-1:ROW_W];
    assign row_dn  = word_q[ROW_W-1:0];

    genvar k;
    generate
        for (k = 0; k < SLICES; k++) begin : g_slice
            assign win[k] = '{nw: row_up[k],  n: row_up[k+1],  ne: row_up[k+2],
                              w:  row_cur[k], c: row_cur[k+1], e:  row_cur[k+2],
                              sw: row_dn[k],  s: row_dn[k+1],  se: row_dn[k+2]};
            skel_cell u_cell (
                .win_i     (win[k]),
                .pass_i    (pass_q),
                .pix_o     (new_pix[k]),
                .removed_o (removed[k])
            );
        end
    endgenerate

    skel_change_tree #(.N(SLICES)) u_tree (
        .flag_i (removed),
        .any_o  (any_removed)
    );

    // Output stage and sticky change flag
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pix_q  <= '0;
            ovld_q <= 1'b0;
            chg_q  <= 1'b0;
        end else begin
            ovld_q <= vld_q;
            if (vld_q) pix_q <= new_pix;
            chg_q <= (chg_q & ~change_clr_i) | (vld_q & any_removed);
        end
    end

    assign pix_o       = pix_q;
    assign out_valid_o = ovld_q;
    assign change_o    = chg_q;

    // R4
    out_follows_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_q |=> out_valid_o);

    // R2
    no_new_pixel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_q |=> ((pix_o & ~$past(row_cur[ROW_W-2:1])) == '0));

    // R5
    tree_agrees_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        any_removed == |(row_cur[ROW_W-2:1] & ~new_pix));

    // R5
    change_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_q && any_removed) |=> change_o);

    // R6
    change_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (change_o && !change_clr_i) |=> change_o);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_q |=> (!out_valid_o && $stable(pix_o)));
endmodule

// File: tb/skel_row_datapath_tb_top.sv
module skel_row_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [29:0] rows;
    logic        pass_sel;
    logic        clr;
    logic [7:0]  pix;
    logic        out_valid;
    logic        change;

    int checks = 0;
    int fails  = 0;
    logic exp_chg;

    always #4 clk = ~clk;

    skel_row_datapath dut_i (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .rows_i(rows),
        .pass_sel_i(pass_sel), .change_clr_i(clr),
        .pix_o(pix), .out_valid_o(out_valid), .change_o(change)
    );

    function automatic int px(logic [29:0] w, int r, int c);
        return int'(w[(2 - r) * 10 + c]);
    endfunction

    function automatic logic model_bit(logic [29:0] w, logic p, int k);
        int nb[8];
        int cnt, rise;
        int N, E, S, W;
        if (px(w, 1, k + 1) == 0) return 1'b0;
        nb[0] = px(w, 0, k + 1); nb[1] = px(w, 0, k + 2);
        nb[2] = px(w, 1, k + 2); nb[3] = px(w, 2, k + 2);
        nb[4] = px(w, 2, k + 1); nb[5] = px(w, 2, k);
        nb[6] = px(w, 1, k);     nb[7] = px(w, 0, k);
        cnt = 0; rise = 0;
        for (int i = 0; i < 8; i++) begin
            cnt += nb[i];
            if (nb[i] == 0 && nb[(i + 1) % 8] == 1) rise++;
        end
        N = nb[0]; E = nb[2]; S = nb[4]; W = nb[6];
        if (cnt < 2 || cnt > 6 || rise != 1) return 1'b1;
        if (p == 1'b0) begin
            if (N * E * S == 0 && E * S * W == 0) return 1'b0;
        end else begin
            if (N * E * W == 0 && N * S * W == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [7:0] model_word(logic [29:0] w, logic p);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = model_bit(w, p, k);
        return r;
    endfunction

    function automatic logic model_removes(logic [29:0] w, logic p);
        return |(w[18:11] & ~model_word(w, p));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load a word; returns at the negedge after the result is registered
    task automatic run_word(logic [29:0] w, logic p, logic clr_with);
        @(negedge clk);
        in_valid = 1'b1; rows = w; pass_sel = p;
        @(negedge clk);
        in_valid = 1'b0; rows = ~w; pass_sel = ~p; clr = clr_with;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [29:0] w;
        logic [7:0]  held;
        logic [29:0] lfsr;
        rst = 1'b1; in_valid = 1'b0; rows = '0; pass_sel = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        // R8
        check("R8 pix", 32'(pix), 32'h0);
        check("R8 valid", 32'(out_valid), 32'h0);
        check("R8 change", 32'(change), 32'h0);
        rst = 1'b0;

        // R5/R6: zero word removes nothing
        run_word('0, 1'b0, 1'b0);
        check("R5 no change", 32'(change), 32'h0);
        check("R4 valid", 32'(out_valid), 32'h1);

        // R7: clear coincident with a removing result
        w = '0; w[11] = 1'b1; w[12] = 1'b1; w[1] = 1'b1; w[2] = 1'b1;
        check("R7 model erodes", 32'(model_removes(w, 1'b0)), 32'h1);
        run_word(w, 1'b0, 1'b1);
        check("R7 set wins", 32'(change), 32'h1);
        check("R2 pix", 32'(pix), 32'(model_word(w, 1'b0)));
        // R4: idle cycle, output held, valid low
        held = pix;
        @(negedge clk);
        check("R4 idle valid", 32'(out_valid), 32'h0);
        check("R4 hold", 32'(pix), 32'(held));
        // R6: sticky across a non-removing result
        run_word('0, 1'b1, 1'b0);
        check("R6 sticky", 32'(change), 32'h1);
        // R6: lone clear
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        check("R6 cleared", 32'(change), 32'h0);

        // R1 R2 R3: sweep all windows, both passes, shifting offsets
        exp_chg = 1'b0;
        for (int p = 0; p < 512; p++) begin
            for (int ps = 0; ps < 2; ps++) begin
                int off;
                off = (p + ps) % 8;
                w = '0;
                for (int b = 0; b < 9; b++)
                    w[(2 - b / 3) * 10 + off + (b % 3)] = p[8 - b];
                run_word(w, 1'(ps), 1'b0);
                exp_chg = exp_chg | model_removes(w, 1'(ps));
                check(ps == 0 ? "R1 R2 R3 pass0" : "R1 R2 R3 pass1",
                      32'(pix), 32'(model_word(w, 1'(ps))));
                check("R5 sticky", 32'(change), 32'(exp_chg));
            end
        end

        // R1 R3: dense pseudo-random words
        lfsr = 30'h2f3a_51c7;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[28:0], lfsr[29] ^ lfsr[28] ^ lfsr[5] ^ lfsr[0]};
            run_word(lfsr, 1'(i % 2), 1'b0);
            check("R1 R3 random", 32'(pix), 32'(model_word(lfsr, 1'(i % 2))));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule